// File: doc/BRIEF.md
# SPI Register-Access Frame Engine

This block is a SPI target that sits in front of a register file. A host opens a frame by pulling chip select low and shifts a command byte, MSB first, followed by either three or four data bytes. The top bit of the command byte marks the access as a write (1) or a read (0), and the remaining seven bits address the register. Data in on MOSI is taken on the rising edge of SCK. Reply data leaves on MISO on the falling edge, inside the same frame, so one frame both addresses a register and returns its contents.

The SCK-domain logic counts clocks and assembles the frame. Once chip select returns high, the frame is passed into the system clock domain, where a write becomes a one-cycle strobe with address and data. This happens only when the frame carried exactly 32 or 40 clocks. The optional fourth data byte is kept only for the two wide addresses 0x00 and 0x10. The read side drives an address to the register file and returns what the file presents. Two fixed-pattern addresses are answered internally, and an address the file does not claim returns zero.

Top module: `sreg_spi_target`

## Requirements
- R1: MOSI is sampled on rising SCK and MISO changes only on falling SCK. MISO is 1 while chip select is high and while the command byte is shifting. SCK and MOSI activity with chip select high has no effect.
- R2: Command bit 7 set means write and clear means read. Bits 6..0 give the address, which appears on `wr_addr_o` with the strobe. Write outputs hold their value between strobes.
- R3: Only frames of exactly 32 or 40 SCK clocks commit. A frame of any other length, including zero clocks, produces no strobe.
- R4: A valid 32-clock write drives `wr_data_o = {data[23:0], 8'h00}` with `wr_ext_o = 0`.
- R5: A valid 40-clock write to 0x00 or 0x10 drives `wr_data_o = {data[23:0], ext[7:0]}` with `wr_ext_o = 1`. At any other address the fourth byte is dropped: the low byte is 0 and `wr_ext_o = 0`.
- R6: After the command byte, MISO shifts out `rd_data_i[31:8]` MSB first for the address on `rd_addr_o`. In a 40-clock frame the fourth byte is `rd_data_i[7:0]` at 0x00 and 0x10, and zero elsewhere.
- R7: Address 0x40 reads 0xAA in all three data bytes and address 0x41 reads 0x55. For both, the fourth byte is zero and `rd_hit_i` is ignored. Writes to these two addresses produce no strobe.
- R8: A read with `rd_hit_i = 0` at a non-pattern address returns all zero data bits.
- R9: The strobe of a valid write rises on the third rising `clk_i` edge after chip select goes high and lasts exactly one cycle. Read frames never strobe.
- R10: While `rst_ni` is low, `wr_stb_o`, `wr_ext_o`, `wr_addr_o` and `wr_data_o` are 0 and `miso_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| rd_addr_o | output | 7 | Address captured from the command byte, used for reads |
| rd_data_i | input | 32 | Register file read word: three data bytes then the fourth byte |
| rd_hit_i | input | 1 | Register file claims `rd_addr_o` |
| wr_stb_o | output | 1 | One-cycle write strobe in the `clk_i` domain |
| wr_addr_o | output | 7 | Write address |
| wr_data_o | output | 32 | Write word: three data bytes then the fourth byte |
| wr_ext_o | output | 1 | Fourth byte in `wr_data_o[7:0]` is valid |

## Verification
Write results come through a two-flop chip-select synchronizer plus one edge-detect register. The strobe is therefore due on the third rising `clk_i` edge after chip select rises. The bench raises chip select 1 ns after a clock edge, then samples 1 ns after each of the next four edges, expecting the strobe only after the third. A scoreboard monitor checks the strobe's contents on falling edges.

MISO bits are launched on a falling SCK edge. The bench reads each one just before the following rising edge, so every reply bit is compared half an SCK period after it was launched. Discarded and read-only frames are checked at the ports: the bench confirms no strobe in any of those four cycles, and the monitor confirms no unexpected item.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
  typedef enum logic [1:0] {LEN_BAD, LEN_SHORT, LEN_LONG} sreg_len_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_FILE, SRC_PAT_A, SRC_PAT_B} sreg_src_e;
endpackage

// File: rtl/sreg_rx_shift.sv
`timescale 1ns/1ps
module sreg_rx_shift #(
  parameter int ADDR_W = 7,
  parameter int SR_W   = 40,
  parameter int CNT_W  = 6
) (
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              rst_ni,
  input  logic              mosi_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SR_W-1:0]   sr_o,
  output logic              tog_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CMD_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic idle_rst;
  logic fresh_q;
  assign idle_rst = csn_i | ~rst_ni;

  // set while deselected: the next SCK edge is bit 1 of a new frame
  always_ff @(posedge sck_i or posedge idle_rst)
    if (idle_rst) fresh_q <= 1'b1;
    else          fresh_q <= 1'b0;

  always_ff @(posedge sck_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_o  <= '0;
      sr_o   <= '0;
      tog_o  <= 1'b0;
      addr_o <= '0;
    end else if (!csn_i) begin
      sr_o <= {sr_o[SR_W-2:0], mosi_i};
      if (fresh_q) begin
        cnt_o <= CNT_W'(1);
        tog_o <= ~tog_o;
      end else if (cnt_o != CNT_MAX) begin
        cnt_o <= cnt_o + 1'b1;
      end
      if (!fresh_q && cnt_o == CNT_W'(CMD_W - 1))
        addr_o <= {sr_o[ADDR_W-2:0], mosi_i};
    end
endmodule

// File: rtl/sreg_tx_shift.sv
`timescale 1ns/1ps
module sreg_tx_shift #(
  parameter int WD_W  = 32,
  parameter int CNT_W = 6,
  parameter int CMD_W = 8
) (
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [WD_W-1:0]  word_i,
  output logic             miso_o
);
  logic            idle_rst;
  logic [WD_W-1:0] tx_q;
  assign idle_rst = csn_i | ~rst_ni;

  always_ff @(negedge sck_i or posedge idle_rst)
    if (idle_rst) begin
      tx_q   <= '0;
      miso_o <= 1'b1;
    end else if (cnt_i == CNT_W'(CMD_W)) begin
      miso_o <= word_i[WD_W-1];
      tx_q   <= {word_i[WD_W-2:0], 1'b0};
    end else if (cnt_i > CNT_W'(CMD_W)) begin
      miso_o <= tx_q[WD_W-1];
      tx_q   <= {tx_q[WD_W-2:0], 1'b0};
    end
endmodule

// File: rtl/sreg_commit.sv
`timescale 1ns/1ps
module sreg_commit #(
  parameter int ADDR_W = 7,
  parameter int DW     = 24,
  parameter int EXT_W  = 8,
  parameter int CNT_W  = 6,
  parameter logic [ADDR_W-1:0] LONG_A0 = 'h00,
  parameter logic [ADDR_W-1:0] LONG_A1 = 'h10,
  parameter logic [ADDR_W-1:0] PAT_A   = 'h40,
  parameter logic [ADDR_W-1:0] PAT_B   = 'h41
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  csn_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [ADDR_W+DW+EXT_W:0] sr_i,
  input  logic                  tog_i,
  output logic                  wr_stb_o,
  output logic [ADDR_W-1:0]     wr_addr_o,
  output logic [DW+EXT_W-1:0]   wr_data_o,
  output logic                  wr_ext_o
);
  import sreg_pkg::*;
  localparam int CMD_W     = ADDR_W + 1;
  localparam int SHORT_LEN = CMD_W + DW;
  localparam int LONG_LEN  = SHORT_LEN + EXT_W;

  logic cs_s1, cs_s2, cs_d, tog_seen, end_ev;
  sreg_len_e len;
  logic [CMD_W-1:0] cmd;
  logic [ADDR_W-1:0] addr;
  logic long_ok, ro, commit, ext;
  logic [DW+EXT_W-1:0] data;

  assign end_ev = cs_s2 & ~cs_d;

  always_comb begin
    if (cnt_i == CNT_W'(SHORT_LEN))     len = LEN_SHORT;
    else if (cnt_i == CNT_W'(LONG_LEN)) len = LEN_LONG;
    else                                len = LEN_BAD;
    cmd     = (len == LEN_LONG) ? sr_i[LONG_LEN-1 -: CMD_W] : sr_i[SHORT_LEN-1 -: CMD_W];
    addr    = cmd[ADDR_W-1:0];
    long_ok = (addr == LONG_A0) || (addr == LONG_A1);
    ro      = (addr == PAT_A) || (addr == PAT_B);
    ext     = (len == LEN_LONG) && long_ok;
    if (len == LEN_LONG)
      data = {sr_i[EXT_W +: DW], long_ok ? sr_i[EXT_W-1:0] : {EXT_W{1'b0}}};
    else
      data = {sr_i[DW-1:0], {EXT_W{1'b0}}};
    // toggle unchanged means no SCK edge arrived in this frame
    commit = end_ev && (tog_i != tog_seen) && (len != LEN_BAD) && cmd[CMD_W-1] && !ro;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      {cs_s1, cs_s2, cs_d} <= 3'b111;
      tog_seen  <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_ext_o  <= 1'b0;
    end else begin
      cs_s1    <= csn_i;
      cs_s2    <= cs_s1;
      cs_d     <= cs_s2;
      wr_stb_o <= commit;
      if (end_ev) tog_seen <= tog_i;
      if (commit) begin
        wr_addr_o <= addr;
        wr_data_o <= data;
        wr_ext_o  <= ext;
      end
    end
endmodule

// File: rtl/sreg_spi_target.sv
`timescale 1ns/1ps
module sreg_spi_target #(
  parameter int ADDR_W = 7,
  parameter int DW     = 24,
  parameter int EXT_W  = 8,
  parameter logic [ADDR_W-1:0] LONG_A0 = 'h00,
  parameter logic [ADDR_W-1:0] LONG_A1 = 'h10,
  parameter logic [ADDR_W-1:0] PAT_A   = 'h40,
  parameter logic [ADDR_W-1:0] PAT_B   = 'h41,
  parameter logic [7:0] PAT_A_VAL = 8'hAA,
  parameter logic [7:0] PAT_B_VAL = 8'h55
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_i,
  input  logic                  csn_i,
  input  logic                  mosi_i,
  output logic                  miso_o,
  output logic [ADDR_W-1:0]     rd_addr_o,
  input  logic [DW+EXT_W-1:0]   rd_data_i,
  input  logic                  rd_hit_i,
  output logic                  wr_stb_o,
  output logic [ADDR_W-1:0]     wr_addr_o,
  output logic [DW+EXT_W-1:0]   wr_data_o,
  output logic                  wr_ext_o
);
  import sreg_pkg::*;
  localparam int CMD_W      = ADDR_W + 1;
  localparam int WD_W       = DW + EXT_W;
  localparam int LONG_LEN   = CMD_W + WD_W;
  localparam int CNT_W      = $clog2(LONG_LEN + 2);
  localparam int DATA_BYTES = DW / 8;

  logic [CNT_W-1:0]    cnt;
  logic [LONG_LEN-1:0] sr;
  logic                tog;
  sreg_src_e           rd_src;
  logic [WD_W-1:0]     rd_word;
  logic                long_rd;

  sreg_rx_shift #(.ADDR_W(ADDR_W), .SR_W(LONG_LEN), .CNT_W(CNT_W)) u_rx (
    .sck_i(sck_i), .csn_i(csn_i), .rst_ni(rst_ni), .mosi_i(mosi_i),
    .cnt_o(cnt), .sr_o(sr), .tog_o(tog), .addr_o(rd_addr_o)
  );

  always_comb begin
    long_rd = (rd_addr_o == LONG_A0) || (rd_addr_o == LONG_A1);
    if (rd_addr_o == PAT_A)      rd_src = SRC_PAT_A;
    else if (rd_addr_o == PAT_B) rd_src = SRC_PAT_B;
    else if (rd_hit_i)           rd_src = SRC_FILE;
    else                         rd_src = SRC_NONE;
    case (rd_src)
      SRC_PAT_A: rd_word = {{DATA_BYTES{PAT_A_VAL}}, {EXT_W{1'b0}}};
      SRC_PAT_B: rd_word = {{DATA_BYTES{PAT_B_VAL}}, {EXT_W{1'b0}}};
      SRC_FILE:  rd_word = long_rd ? rd_data_i : {rd_data_i[WD_W-1:EXT_W], {EXT_W{1'b0}}};
      default:   rd_word = '0;
    endcase
  end

  sreg_tx_shift #(.WD_W(WD_W), .CNT_W(CNT_W), .CMD_W(CMD_W)) u_tx (
    .sck_i(sck_i), .csn_i(csn_i), .rst_ni(rst_ni), .cnt_i(cnt),
    .word_i(rd_word), .miso_o(miso_o)
  );

  sreg_commit #(
    .ADDR_W(ADDR_W), .DW(DW), .EXT_W(EXT_W), .CNT_W(CNT_W),
    .LONG_A0(LONG_A0), .LONG_A1(LONG_A1), .PAT_A(PAT_A), .PAT_B(PAT_B)
  ) u_commit (
    .clk_i(clk_i), .rst_ni(rst_ni), .csn_i(csn_i), .cnt_i(cnt), .sr_i(sr),
    .tog_i(tog), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_ext_o(wr_ext_o)
  );
endmodule

// File: rtl/sreg_spi_target_chk.sv
`timescale 1ns/1ps
module sreg_spi_target_chk #(
  parameter int ADDR_W = 7,
  parameter int WD_W   = 32,
  parameter int EXT_W  = 8,
  parameter logic [ADDR_W-1:0] LONG_A0 = 'h00,
  parameter logic [ADDR_W-1:0] LONG_A1 = 'h10,
  parameter logic [ADDR_W-1:0] PAT_A   = 'h40,
  parameter logic [ADDR_W-1:0] PAT_B   = 'h41
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic              miso_o,
  input logic              wr_stb_o,
  input logic              wr_ext_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [WD_W-1:0]   wr_data_o
);
  AST_IDLE_MISO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |-> miso_o); // R1
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R9
  AST_STB_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> csn_i); // R9
  AST_EXT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && wr_ext_o) |-> (wr_addr_o == LONG_A0 || wr_addr_o == LONG_A1)); // R5
  AST_SHORT_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && !wr_ext_o) |-> (wr_data_o[EXT_W-1:0] == '0)); // R4
  AST_RO_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (wr_addr_o != PAT_A && wr_addr_o != PAT_B)); // R7
  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wr_data_o) |-> wr_stb_o); // R2
endmodule

bind sreg_spi_target sreg_spi_target_chk #(
  .ADDR_W(ADDR_W), .WD_W(WD_W), .EXT_W(EXT_W),
  .LONG_A0(LONG_A0), .LONG_A1(LONG_A1), .PAT_A(PAT_A), .PAT_B(PAT_B)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_i(csn_i), .miso_o(miso_o),
  .wr_stb_o(wr_stb_o), .wr_ext_o(wr_ext_o), .wr_addr_o(wr_addr_o),
  .wr_data_o(wr_data_o)
);

// File: tb/sim_sreg_spi_target.sv
`timescale 1ns/1ps
module sim_sreg_spi_target;
  typedef struct packed {
    logic [6:0]  a;
    logic [31:0] d;
    logic        e;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0, sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, wr_stb, wr_ext, rd_hit;
  logic [6:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  int n_chk = 0, n_fail = 0;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] file_val(input logic [6:0] a);
    return {8'hC3 ^ {1'b0, a}, 8'h3C, 8'h96 ^ {1'b0, a}, 8'hE1};
  endfunction
  assign rd_data = file_val(rd_addr);
  assign rd_hit  = (rd_addr < 7'h20);

  sreg_spi_target u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rd_hit_i(rd_hit),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ext_o(wr_ext)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && wr_stb) begin
      if (sbq.size() == 0) chk(1'b0, "R3", "unexpected strobe", {25'd0, wr_addr, wr_data}, 64'd0);
      else begin
        item_t x;
        x = sbq.pop_front();
        chk(wr_addr === x.a, "R2", "wr_addr", {57'd0, wr_addr}, {57'd0, x.a});
        chk(wr_data === x.d, "R4/R5 data", "wr_data", {32'd0, wr_data}, {32'd0, x.d});
        chk(wr_ext === x.e, "R5", "wr_ext", {63'd0, wr_ext}, {63'd0, x.e});
      end
    end
  end

  task automatic frame(input int nbits, input logic [47:0] bits, input logic exp_stb,
                       input item_t it, input logic chk_rx, input logic [47:0] exp_rx,
                       input string tag);
    logic [47:0] rx, mask;
    rx = '1;
    if (exp_stb) sbq.push_back(it);
    csn = 1'b0; #20;
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[47-i]; #10;
      rx[47-i] = miso;
      sck = 1'b1; #20;
      sck = 1'b0; #10;
    end
    #20; @(posedge clk); #1; csn = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #1;
      chk(wr_stb === (exp_stb && k == 3), "R9", {tag, " strobe timing"},
          {63'd0, wr_stb}, {63'd0, exp_stb && k == 3});
    end
    if (chk_rx) begin
      mask = ~((48'h1 << (48 - nbits)) - 48'h1);
      chk((rx & mask) === (exp_rx & mask), tag, "miso frame", {16'd0, rx & mask}, {16'd0, exp_rx & mask});
    end
    chk(miso === 1'b1, "R1", "miso idle", {63'd0, miso}, 64'd1);
    repeat (6) @(posedge clk);
  endtask

  task automatic wr(input int nbits, input logic [6:0] a, input logic [23:0] d,
                    input logic [7:0] e, input logic exp_stb, input string tag);
    item_t it;
    logic lng;
    lng = (nbits == 40) && (a == 7'h00 || a == 7'h10);
    it = '{a: a, d: {d, lng ? e : 8'h00}, e: lng};
    frame(nbits, {1'b1, a, d, e, 8'h00}, exp_stb, it, 1'b0, '0, tag);
  endtask

  task automatic rd(input int nbits, input logic [6:0] a, input logic [31:0] exp_word,
                    input string tag);
    frame(nbits, {1'b0, a, 40'h0}, 1'b0, '0, 1'b1, {8'hFF, exp_word, 8'h00}, tag);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk(miso === 1'b1, "R10", "reset miso", {63'd0, miso}, 64'd1);
    chk(wr_stb === 1'b0 && wr_ext === 1'b0, "R10", "reset strobe/ext", {62'd0, wr_stb, wr_ext}, 64'd0);
    chk(wr_data === 32'd0 && wr_addr === 7'd0, "R10", "reset data/addr", {25'd0, wr_addr, wr_data}, 64'd0);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);

    wr(32, 7'h0B, 24'h123456, 8'h00, 1'b1, "R4");     // short write
    wr(40, 7'h00, 24'hA1B2C3, 8'h5D, 1'b1, "R5");     // wide at 0x00
    wr(40, 7'h10, 24'h0F1E2D, 8'hC7, 1'b1, "R5");     // wide at 0x10
    wr(40, 7'h0C, 24'h778899, 8'hEE, 1'b1, "R5");     // fourth byte dropped
    wr(31, 7'h0B, 24'hFFFFFF, 8'h00, 1'b0, "R3");
    wr(33, 7'h0B, 24'hFFFFFF, 8'h00, 1'b0, "R3");
    wr(39, 7'h00, 24'hFFFFFF, 8'hFF, 1'b0, "R3");
    wr(41, 7'h00, 24'hFFFFFF, 8'hFF, 1'b0, "R3");
    wr(0,  7'h00, 24'h0, 8'h0, 1'b0, "R3");           // zero-clock frame
    wr(32, 7'h40, 24'h010203, 8'h00, 1'b0, "R7");     // read-only pattern
    wr(40, 7'h41, 24'h010203, 8'h04, 1'b0, "R7");

    // SCK and MOSI noise while deselected (R1), then a clean write
    for (int n = 0; n < 9; n++) begin
      mosi = n[0]; #10; sck = 1'b1; #10; sck = 1'b0;
    end
    chk(miso === 1'b1 && wr_stb === 1'b0, "R1", "noise while deselected", {62'd0, miso, wr_stb}, 64'd2);
    wr(32, 7'h05, 24'hCAFE01, 8'h00, 1'b1, "R1");

    rd(32, 7'h0B, {file_val(7'h0B)[31:8], 8'h00}, "R6");
    rd(40, 7'h10, file_val(7'h10), "R6");
    rd(40, 7'h02, {file_val(7'h02)[31:8], 8'h00}, "R6");
    rd(40, 7'h40, 32'hAAAAAA00, "R7");
    rd(32, 7'h41, 32'h55555500, "R7");
    rd(40, 7'h30, 32'h0, "R8");
    rd(40, 7'h7F, 32'h0, "R8");

    repeat (10) @(posedge clk);
    chk(sbq.size() == 0, "R9", "missing strobes", 64'(sbq.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule